// File: doc/BRIEF.md
# Auto-Detecting Dual-Bus Host Port

This block is the slave side of a parallel host bus for a switching chip. It connects a CPU to the chip's internal control registers and channel memories. A strap input chooses between two addressing styles. In the non-multiplexed style, eight dedicated address pins carry the address. In the multiplexed style, the host puts the address on the low byte of the data bus and marks it with an address-latch pulse.

In the multiplexed style the port works out the host's bus timing on its own. On every rising edge of the address latch it samples the level of the shared strobe pin:

- **Low** selects a data strobe plus a read/write direction line.
- **High** selects separate active-low read and write strobes.

The non-multiplexed style always uses the data-strobe timing.

All bus pins pass through a synchronizer into the core clock domain. Each qualified strobe produces one request pulse towards either the register bank or the memory space. A fixed number of clocks later, the port pulls the open-drain transfer-acknowledge line low. It holds that line low until the strobe or the chip select is released. Read data is placed on the data bus while a read strobe is active.

The internal request side is a plain one-cycle pulse with no back-pressure. The register and memory logic must return read data combinationally from the held index and channel outputs by the next clock.

Top module: `hostbus_slave`

## Requirements
- R1: After reset, `ack_pull`, `dq_oe`, `reg_req` and `mem_req` are all 0, and the multiplexed-mode protocol is data-strobe timing.
- R2: With `mux_mode` = 0, the address comes from `addr`. An access is strobed by `ds_rd` = 1 with `cs_n` = 0. `rw_wr` = 1 means read and `rw_wr` = 0 means write, and write data is taken from `dq_in`.
- R3: With `mux_mode` = 1, `ds_rd` = 0 at a rising edge of `as_ale` selects data-strobe timing, which is strobed and directed as in R2.
- R4: With `mux_mode` = 1, `ds_rd` = 1 at a rising edge of `as_ale` selects split-strobe timing. In this timing `ds_rd` = 0 is a read and `rw_wr` = 0 is a write, each qualified by `cs_n` = 0.
- R5: With `mux_mode` = 1, the address is `dq_in[7:0]` captured at the falling edge of `as_ale`. The `addr` pins are ignored.
- R6: Address bit 7 = 0 targets the register bank. Offsets 0 to 6 (bits 6:0) issue `reg_req` with `reg_idx` = offset. Any other offset issues no request, is still acknowledged, and reads as 0.
- R7: Address bit 7 = 1 targets memory. `mem_req` is issued with `mem_chan` = address bits 6:0, and `mem_conn` = `mem_sel_cfg`, where 1 means connect memory and 0 means data memory.
- R8: A write with address bit 7 = 1 while `mem_sel_cfg` = 0 (data memory) issues no request, and it is still acknowledged.
- R9: `ack_pull` rises exactly ACK_DELAY clocks after the synchronized strobe is first seen active. It falls in the first cycle in which the synchronized strobe or chip select is inactive.
- R10: `dq_oe` is 1 while a read strobe is active with `cs_n` = 0. `dq_out` holds the read data whenever `ack_pull` is 1 during a read.
- R11: Each strobe produces at most one request. The request is a single-cycle pulse, and `reg_req` and `mem_req` are never high together.
- R12: With `cs_n` = 1, strobe activity produces no request and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| mux_mode | input | 1 | 1 = multiplexed address/data, 0 = separate address pins |
| cs_n | input | 1 | Chip select, active low |
| as_ale | input | 1 | Address strobe / latch enable (multiplexed only) |
| ds_rd | input | 1 | Data strobe (active high) or read strobe (active low) |
| rw_wr | input | 1 | Read/write direction or write strobe (active low) |
| addr | input | 8 | Address pins (non-multiplexed) |
| dq_in | input | 16 | Data bus, input side |
| dq_out | output | 16 | Data bus, output side |
| dq_oe | output | 1 | Data bus output enable |
| ack_pull | output | 1 | 1 = pull the open-drain acknowledge line low |
| mem_sel_cfg | input | 1 | Memory select from control register: 1 connect, 0 data |
| reg_req | output | 1 | Register access pulse |
| reg_we | output | 1 | Register access is a write |
| reg_idx | output | 3 | Register offset |
| reg_rdata | input | 16 | Register read data |
| mem_req | output | 1 | Memory access pulse |
| mem_we | output | 1 | Memory access is a write |
| mem_conn | output | 1 | 1 = connect memory, 0 = data memory |
| mem_chan | output | 7 | Memory channel location |
| mem_rdata | input | 16 | Memory read data |
| wr_data | output | 16 | Write data for either target |

## Verification
The bench builds the port with its defaults: SYNC_STAGES = 2 and ACK_DELAY = 2. The acknowledge therefore rises on the fourth clock after a strobe pin changes, and falls on the second clock after release. The bench samples both sides of each edge, so an off-by-one in the synchronizer or the acknowledge counter shows up. With 16-bit data and an 8-bit address, the full decode can be exercised:

- every register offset class;
- both memory selects;
- the dropped data-memory write;
- switching between the two multiplexed timings within one run.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
  localparam int REG_COUNT = 7;
  localparam int REG_IDX_W = $clog2(REG_COUNT);

  typedef enum logic {
    PROTO_STROBE = 1'b0,
    PROTO_SPLIT  = 1'b1
  } proto_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REG  = 2'd1,
    TGT_MEM  = 2'd2
  } tgt_e;
endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/hostbus_detect.sv
module hostbus_detect
  import hostbus_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux,
  input  logic              ale,
  input  logic              ds_lvl,
  input  logic [ADDR_W-1:0] dq_lo,
  output proto_e            proto,
  output logic [ADDR_W-1:0] lat_addr
);
  logic ale_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q    <= 1'b0;
      proto    <= PROTO_STROBE;
      lat_addr <= '0;
    end else begin
      ale_q <= ale;
      if (mux && ale && !ale_q)
        proto <= ds_lvl ? PROTO_SPLIT : PROTO_STROBE;
      if (mux && !ale && ale_q)
        lat_addr <= dq_lo;
    end
  end
endmodule

// File: rtl/hostbus_decode.sv
module hostbus_decode
  import hostbus_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic              mem_sel,
  output tgt_e              tgt
);
  localparam int OFFS_W = ADDR_W - 1;
  localparam logic [OFFS_W-1:0] REG_LIM = OFFS_W'(REG_COUNT);

  always_comb begin
    tgt = TGT_NONE;
    if (!addr[ADDR_W-1]) begin
      if (addr[OFFS_W-1:0] < REG_LIM) tgt = TGT_REG;
    end else if (!(is_write && !mem_sel)) begin
      tgt = TGT_MEM;
    end
  end
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
  import hostbus_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ACK_DELAY   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mux_mode,
  input  logic                 cs_n,
  input  logic                 as_ale,
  input  logic                 ds_rd,
  input  logic                 rw_wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    dq_in,
  output logic [DATA_W-1:0]    dq_out,
  output logic                 dq_oe,
  output logic                 ack_pull,
  input  logic                 mem_sel_cfg,
  output logic                 reg_req,
  output logic                 reg_we,
  output logic [REG_IDX_W-1:0] reg_idx,
  input  logic [DATA_W-1:0]    reg_rdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic                 mem_conn,
  output logic [ADDR_W-2:0]    mem_chan,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [DATA_W-1:0]    wr_data
);
  localparam int PIN_W = 5 + ADDR_W + DATA_W;
  localparam logic [PIN_W-1:0] PIN_RST = {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
  localparam int CNT_W = $clog2(ACK_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(ACK_DELAY);

  logic              s_mux, s_cs_n, s_ale, s_ds, s_rw;
  logic [ADDR_W-1:0] s_addr, lat_addr, eff_addr;
  logic [DATA_W-1:0] s_dq;
  proto_e            proto;
  tgt_e              tgt, acc_tgt;
  logic              strobe_mode, bus_active, is_read;
  logic [CNT_W-1:0]  cnt;

  hostbus_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({mux_mode, cs_n, as_ale, ds_rd, rw_wr, addr, dq_in}),
    .dout({s_mux, s_cs_n, s_ale, s_ds, s_rw, s_addr, s_dq})
  );

  hostbus_detect #(.ADDR_W(ADDR_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .mux(s_mux), .ale(s_ale), .ds_lvl(s_ds),
    .dq_lo(s_dq[ADDR_W-1:0]), .proto(proto), .lat_addr(lat_addr)
  );

  assign strobe_mode = !s_mux || (proto == PROTO_STROBE);
  assign eff_addr    = s_mux ? lat_addr : s_addr;
  assign bus_active  = !s_cs_n && (strobe_mode ? s_ds : (!s_ds || !s_rw));
  assign is_read     = strobe_mode ? s_rw : !s_ds;

  hostbus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr(eff_addr), .is_write(!is_read), .mem_sel(mem_sel_cfg), .tgt(tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      acc_tgt  <= TGT_NONE;
      reg_req  <= 1'b0;
      reg_we   <= 1'b0;
      reg_idx  <= '0;
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      mem_conn <= 1'b0;
      mem_chan <= '0;
      wr_data  <= '0;
      dq_out   <= '0;
    end else begin
      reg_req <= 1'b0;
      mem_req <= 1'b0;
      if (!bus_active) begin
        cnt <= '0;
      end else begin
        if (cnt != CNT_ACK) cnt <= cnt + 1'b1;
        if (cnt == '0) begin
          acc_tgt <= tgt;
          wr_data <= s_dq;
          if (tgt == TGT_REG) begin
            reg_req <= 1'b1;
            reg_we  <= !is_read;
            reg_idx <= eff_addr[REG_IDX_W-1:0];
          end
          if (tgt == TGT_MEM) begin
            mem_req  <= 1'b1;
            mem_we   <= !is_read;
            mem_conn <= mem_sel_cfg;
            mem_chan <= eff_addr[ADDR_W-2:0];
          end
        end
        if (cnt == CNT_W'(1)) begin
          case (acc_tgt)
            TGT_REG: dq_out <= reg_rdata;
            TGT_MEM: dq_out <= mem_rdata;
            default: dq_out <= '0;
          endcase
        end
      end
    end
  end

  assign ack_pull = bus_active && (cnt == CNT_ACK);
  assign dq_oe    = bus_active && is_read;
endmodule

// File: rtl/hostbus_slave_chk.sv
module hostbus_slave_chk
  import hostbus_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ack_pull,
  input logic                 reg_req,
  input logic                 mem_req,
  input logic                 mem_we,
  input logic                 mem_conn,
  input logic [REG_IDX_W-1:0] reg_idx,
  input logic                 active,
  input logic                 cs_n_s
);
  a_r11_one_cycle_req: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req || mem_req) |=> !(reg_req || mem_req));

  a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && mem_req));

  a_r8_no_dmem_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_conn);

  a_r6_reg_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> (int'(reg_idx) < REG_COUNT));

  a_r9_ack_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pull) |-> ($past(active) && $past(active, 2)));

  a_r12_ack_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pull |-> !cs_n_s);
endmodule

bind hostbus_slave hostbus_slave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ack_pull(ack_pull), .reg_req(reg_req),
  .mem_req(mem_req), .mem_we(mem_we), .mem_conn(mem_conn), .reg_idx(reg_idx),
  .active(bus_active), .cs_n_s(s_cs_n)
);

// File: tb/test_hostbus_slave.sv
module test_hostbus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int ACKD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mux_mode = 1'b0, cs_n = 1'b1, as_ale = 1'b0, ds_rd = 1'b0, rw_wr = 1'b1;
  logic [7:0] addr = '0;
  logic [15:0] dq_in = '0, dq_out, reg_rdata, mem_rdata, wr_data;
  logic dq_oe, ack_pull, mem_sel_cfg = 1'b0;
  logic reg_req, reg_we, mem_req, mem_we, mem_conn;
  logic [2:0] reg_idx;
  logic [6:0] mem_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostbus_slave i_hostbus_slave (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .cs_n(cs_n), .as_ale(as_ale),
    .ds_rd(ds_rd), .rw_wr(rw_wr), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .ack_pull(ack_pull), .mem_sel_cfg(mem_sel_cfg),
    .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_conn(mem_conn), .mem_chan(mem_chan),
    .mem_rdata(mem_rdata), .wr_data(wr_data)
  );

  assign reg_rdata = {8'h5A, 5'd0, reg_idx};
  assign mem_rdata = {(mem_conn ? 8'hC0 : 8'hD0), 1'b0, mem_chan};

  typedef struct packed {
    logic        is_mem;
    logic        we;
    logic [6:0]  where;
    logic        conn;
    logic [15:0] wd;
  } exp_t;

  exp_t  q[$];
  string qtag[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a request pulse appears (R11)
  always @(negedge clk) begin
    if (rst_n && (reg_req || mem_req)) begin
      if (q.size() == 0) begin
        check(0, "R11", "unexpected request", {reg_req, mem_req}, 0);
      end else begin
        exp_t  e;
        string t;
        exp_t  a;
        e = q.pop_front();
        t = qtag.pop_front();
        a.is_mem = mem_req;
        a.we     = mem_req ? mem_we : reg_we;
        a.where  = mem_req ? mem_chan : {4'd0, reg_idx};
        a.conn   = mem_req ? mem_conn : 1'b0;
        a.wd     = a.we ? wr_data : 16'h0;
        check(!(reg_req && mem_req) && (a == e), t, "request fields", 32'(a), 32'(e));
      end
    end
  end

  task automatic set_idle(bit split);
    cs_n = 1'b1; as_ale = 1'b0; rw_wr = 1'b1; ds_rd = split;
  endtask

  task automatic access(bit mux, bit split, logic [7:0] a, bit rd, logic [15:0] wd, bit msel, string rq);
    exp_t e;
    bit   has_req;
    logic [15:0] exp_rd;
    @(negedge clk);
    mem_sel_cfg = msel; mux_mode = mux; set_idle(mux && split);
    // bench model of the decode (R6, R7, R8)
    has_req = 1'b0; exp_rd = 16'h0;
    e.is_mem = a[7]; e.we = !rd; e.conn = a[7] ? msel : 1'b0;
    e.where = a[7] ? a[6:0] : {4'd0, a[2:0]};
    e.wd = rd ? 16'h0 : wd;
    if (!a[7] && a[6:0] <= 7'd6) begin has_req = 1'b1; exp_rd = {8'h5A, 5'd0, a[2:0]}; end
    if (a[7] && !(!rd && !msel)) begin has_req = 1'b1; exp_rd = {(msel ? 8'hC0 : 8'hD0), 1'b0, a[6:0]}; end
    if (mux) begin
      dq_in = {8'h00, a}; addr = ~a;
      repeat (3) @(negedge clk);
      as_ale = 1'b1;
      repeat (3) @(negedge clk);
      as_ale = 1'b0;
      repeat (3) @(negedge clk);
      dq_in = rd ? 16'hFFFF : wd;
    end else begin
      addr = a; dq_in = wd;
      repeat (3) @(negedge clk);
    end
    if (has_req) begin q.push_back(e); qtag.push_back(rq); end
    cs_n = 1'b0;
    if (!mux || !split) begin rw_wr = rd; ds_rd = 1'b1; end
    else if (rd) ds_rd = 1'b0;
    else rw_wr = 1'b0;
    repeat (SYNC + ACKD - 1) @(negedge clk);
    check(ack_pull == 1'b0, "R9", "ack early", ack_pull, 0);
    @(negedge clk);
    check(ack_pull == 1'b1, "R9", "ack on time", ack_pull, 1);
    if (rd) begin
      check(dq_oe == 1'b1, "R10", "read oe", dq_oe, 1);
      check(dq_out == exp_rd, rq, "read data", dq_out, exp_rd);
    end else begin
      check(dq_oe == 1'b0, "R10", "no oe on write", dq_oe, 0);
    end
    set_idle(mux && split);
    repeat (SYNC) @(negedge clk);
    check(ack_pull == 1'b0, "R9", "ack release", ack_pull, 0);
    check(dq_oe == 1'b0, "R10", "oe release", dq_oe, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog expired: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ack_pull && !dq_oe && !reg_req && !mem_req, "R1", "reset outputs",
          {ack_pull, dq_oe, reg_req, mem_req}, 0);

    access(0, 0, 8'h01, 0, 16'h1234, 0, "R2");
    access(0, 0, 8'h02, 1, 16'h0000, 0, "R2");
    access(0, 0, 8'h07, 1, 16'h0000, 0, "R6");
    access(0, 0, 8'h0E, 0, 16'h4444, 0, "R6");
    access(0, 0, 8'h85, 0, 16'hBEEF, 1, "R7");
    access(0, 0, 8'h85, 0, 16'h5555, 0, "R8");
    access(0, 0, 8'hFF, 1, 16'h0000, 0, "R7");
    access(1, 0, 8'h03, 0, 16'hA5C3, 0, "R3/R5");
    access(1, 1, 8'h04, 1, 16'h0000, 0, "R4/R5");
    access(1, 1, 8'h90, 0, 16'h0F0F, 1, "R4");
    access(1, 0, 8'h81, 1, 16'h0000, 1, "R3");
    access(0, 0, 8'h00, 1, 16'h0000, 0, "R2");

    // R12: strobe with chip select high
    @(negedge clk);
    mux_mode = 1'b0; addr = 8'h01; cs_n = 1'b1; rw_wr = 1'b0; ds_rd = 1'b1;
    repeat (8) @(negedge clk);
    check(ack_pull == 1'b0, "R12", "no ack without cs", ack_pull, 0);
    check(dq_oe == 1'b0, "R12", "no oe without cs", dq_oe, 0);
    set_idle(0);
    repeat (4) @(negedge clk);

    check(q.size() == 0, "R11", "requests outstanding", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule